// File: doc/BRIEF.md
# Delayed Synaptic Input Ring Accumulator

This block keeps future input for a group of model neurons. Each neuron has two receptor channels. Channel 0 is excitatory and channel 1 is inhibitory. Each channel owns a ring of sixteen 16-bit unsigned slots. All rings share one pointer, and that pointer marks the slot that feeds the coming timestep.

A spike event enters through the accumulate port. The port carries a neuron index, a receptor channel, a 4-bit delay and an unsigned weight. The weight is added, with saturation, into the slot that lies that many timesteps ahead of the pointer.

During the neuron update, the read port is used once per neuron and channel. It returns the slot under the pointer as a 32-bit fixed-point value with 15 fractional bits, scaled by a programmable left shift, and it empties that slot. A single-cycle step strobe then moves the pointer on to the next timestep.

Top module: `syn_ring_accum`

## Requirements
- R1: After reset every slot of every ring is zero, the pointer is at slot 0, `rd_data_valid` is low and `rd_data` is zero.
- R2: An accumulate writes into slot (pointer + `acc_delay`) mod 16. A delay of 0 selects the pointer slot itself, which is the same slot a delay of 16 would select.
- R3: Weights that target the same slot are summed.
- R4: A slot saturates at 16'hFFFF and never wraps. A sum of exactly 16'hFFFF is stored unchanged.
- R5: Each neuron and channel (`acc_rcpt`/`rd_rcpt`: 0 excitatory, 1 inhibitory) has its own ring. An accumulate changes no other ring.
- R6: A read taken at a rising edge presents its result on `rd_data` one cycle later, with `rd_data_valid` high for that one cycle. In every other cycle `rd_data_valid` is low.
- R7: A read clears the slot it consumed, so a second read in the same timestep returns zero.
- R8: A `step` pulse advances the pointer by one, wrapping from slot 15 to slot 0. A read in the same cycle as a step uses the old pointer. Without a step the pointer holds.
- R9: `rd_data` is the 16-bit slot value zero-extended to 32 bits and shifted left by `rd_shift` (0 to 15). Output bit k is worth 2^(k-15), so a shift of 6 gives the slot LSB a weight of 2^-9. Bit 31 is never set.
- R10: When an accumulate and a read target the same slot in the same cycle, the read returns the value held before the add. The slot then holds only the new weight, and that weight is delivered when the pointer next reaches the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Timestep advance strobe |
| acc_valid | input | 1 | Accumulate request |
| acc_neuron | input | NIDX_W | Target neuron index |
| acc_rcpt | input | 1 | Target channel, 0 excitatory, 1 inhibitory |
| acc_delay | input | DELAY_W | Timesteps ahead of the pointer (0 means 16) |
| acc_weight | input | SLOT_W | Unsigned weight to add |
| rd_valid | input | 1 | Read-and-clear request |
| rd_neuron | input | NIDX_W | Neuron to read |
| rd_rcpt | input | 1 | Channel to read |
| rd_shift | input | SHIFT_W | Left shift applied on conversion |
| rd_data_valid | output | 1 | Read result present |
| rd_data | output | OUT_W | Fixed-point read result |

## Verification
An accumulate and a read-and-clear can land on the same slot in one cycle. This happens when the accumulate uses delay 0 and names the same neuron and channel that is being read. The bench first preloads that slot with a known weight. It then issues both operations in one cycle and expects the preloaded value back, not the sum. After sixteen further steps it reads the slot again and expects exactly the new weight. A read issued in the same cycle as a step is also checked: the read must take the pre-step slot.

// File: rtl/syn_ring_pkg.sv
package syn_ring_pkg;
   localparam int NUM_RCPT = 2;
   typedef enum logic {
      RCPT_EXC = 1'b0,
      RCPT_INH = 1'b1
   } rcpt_e;
endpackage

// File: rtl/syn_ring_ptr.sv
module syn_ring_ptr #(
   parameter int DEPTH_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   output logic [DEPTH_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr <= '0;
      else if (step) ptr <= ptr + DEPTH_W'(1);
   end

   // R8
   ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ptr == $past(ptr) + DEPTH_W'(1));
   // R8
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(ptr));
endmodule

// File: rtl/syn_slot_bank.sv
module syn_slot_bank #(
   parameter int SLOT_W  = 16,
   parameter int DEPTH_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DEPTH_W-1:0] ptr,
   input  logic               acc_en,
   input  logic [DEPTH_W-1:0] acc_slot,
   input  logic [SLOT_W-1:0]  acc_weight,
   input  logic               rd_en,
   output logic [SLOT_W-1:0]  head
);
   localparam int DEPTH = 1 << DEPTH_W;

   logic [SLOT_W-1:0] mem [DEPTH];
   logic              collide;
   logic [SLOT_W-1:0] base;
   logic [SLOT_W:0]   sum;
   logic [SLOT_W-1:0] upd;

   always_comb begin
      collide = rd_en && (acc_slot == ptr);
      base    = collide ? '0 : mem[acc_slot];
      sum     = {1'b0, base} + {1'b0, acc_weight};
      upd     = sum[SLOT_W] ? {SLOT_W{1'b1}} : sum[SLOT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (rd_en)  mem[ptr]      <= '0;
         if (acc_en) mem[acc_slot] <= upd;
      end
   end

   assign head = mem[ptr];

   logic               chk_acc, chk_col, chk_rd;
   logic [DEPTH_W-1:0] chk_slot, chk_rslot;
   logic [SLOT_W-1:0]  chk_old, chk_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_acc <= 1'b0; chk_col <= 1'b0; chk_rd <= 1'b0;
         chk_slot <= '0; chk_rslot <= '0; chk_old <= '0; chk_w <= '0;
      end else begin
         chk_acc   <= acc_en;
         chk_col   <= acc_en && collide;
         chk_rd    <= rd_en;
         chk_slot  <= acc_slot;
         chk_rslot <= ptr;
         chk_old   <= mem[acc_slot];
         chk_w     <= acc_weight;
      end
   end

   // R4
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_acc && !chk_col) |-> mem[chk_slot] >= chk_old);
   // R7
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_rd && !(chk_acc && chk_slot == chk_rslot)) |-> mem[chk_rslot] == '0);
   // R10
   collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_col |-> mem[chk_slot] == chk_w);
endmodule

// File: rtl/syn_fx_convert.sv
module syn_fx_convert #(
   parameter int SLOT_W  = 16,
   parameter int SHIFT_W = 4,
   parameter int OUT_W   = 32
) (
   input  logic [SLOT_W-1:0]  slot_val,
   input  logic [SHIFT_W-1:0] shift,
   output logic [OUT_W-1:0]   fx_val
);
   localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;

   if (OUT_W < SLOT_W + MAX_SHIFT + 1) begin : g_bad_width
      $error("OUT_W too narrow for SLOT_W plus the largest shift and a clear sign bit");
   end

   if (SHIFT_W == 0) begin : g_fixed
      assign fx_val = OUT_W'(slot_val);
   end else begin : g_shift
      assign fx_val = OUT_W'(slot_val) << shift;
   end
endmodule

// File: rtl/syn_ring_accum.sv
module syn_ring_accum
   import syn_ring_pkg::*;
#(
   parameter int N_NEURONS = 8,
   parameter int SLOT_W    = 16,
   parameter int DELAY_W   = 4,
   parameter int SHIFT_W   = 4,
   parameter int OUT_W     = 32,
   localparam int NIDX_W   = (N_NEURONS > 1) ? $clog2(N_NEURONS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic               acc_valid,
   input  logic [NIDX_W-1:0]  acc_neuron,
   input  logic               acc_rcpt,
   input  logic [DELAY_W-1:0] acc_delay,
   input  logic [SLOT_W-1:0]  acc_weight,
   input  logic               rd_valid,
   input  logic [NIDX_W-1:0]  rd_neuron,
   input  logic               rd_rcpt,
   input  logic [SHIFT_W-1:0] rd_shift,
   output logic               rd_data_valid,
   output logic [OUT_W-1:0]   rd_data
);
   localparam int NBUF   = N_NEURONS * NUM_RCPT;
   localparam int BIDX_W = NIDX_W + 1;

   if (N_NEURONS < 1) begin : g_bad_n
      $error("N_NEURONS must be at least 1");
   end
   if (SLOT_W < 2 || DELAY_W < 1) begin : g_bad_slot
      $error("SLOT_W must be at least 2 and DELAY_W at least 1");
   end

   logic [DELAY_W-1:0] ptr;
   logic [DELAY_W-1:0] acc_slot;
   logic [BIDX_W-1:0]  acc_idx, rd_idx;
   rcpt_e              acc_ch, rd_ch;
   logic [SLOT_W-1:0]  heads [NBUF];
   logic [SLOT_W-1:0]  rd_sel;
   logic [OUT_W-1:0]   fx_val;

   assign acc_ch   = rcpt_e'(acc_rcpt);
   assign rd_ch    = rcpt_e'(rd_rcpt);
   assign acc_idx  = {acc_neuron, acc_ch};
   assign rd_idx   = {rd_neuron, rd_ch};
   assign acc_slot = ptr + acc_delay;

   syn_ring_ptr #(.DEPTH_W(DELAY_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .step(step), .ptr(ptr)
   );

   for (genvar g = 0; g < NBUF; g++) begin : g_bank
      logic acc_hit, rd_hit;
      assign acc_hit = acc_valid && (acc_idx == BIDX_W'(g));
      assign rd_hit  = rd_valid  && (rd_idx  == BIDX_W'(g));
      syn_slot_bank #(.SLOT_W(SLOT_W), .DEPTH_W(DELAY_W)) u_bank (
         .clk(clk), .rst_n(rst_n), .ptr(ptr),
         .acc_en(acc_hit), .acc_slot(acc_slot), .acc_weight(acc_weight),
         .rd_en(rd_hit), .head(heads[g])
      );
   end

   always_comb begin
      rd_sel = '0;
      for (int i = 0; i < NBUF; i++)
         if (rd_idx == BIDX_W'(i)) rd_sel = heads[i];
   end

   syn_fx_convert #(.SLOT_W(SLOT_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) u_fx (
      .slot_val(rd_sel), .shift(rd_shift), .fx_val(fx_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_valid <= 1'b0;
         rd_data       <= '0;
      end else begin
         rd_data_valid <= rd_valid;
         if (rd_valid) rd_data <= fx_val;
      end
   end

   // R6
   rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> rd_data_valid);
   // R6
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> !rd_data_valid);
   // R9
   sign_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_valid |-> !rd_data[OUT_W-1]);
endmodule

// File: tb/syn_ring_accum_bench.sv
module syn_ring_accum_bench;
   localparam int N  = 4;
   localparam int NW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          step = 1'b0;
   logic          acc_valid = 1'b0;
   logic [NW-1:0] acc_neuron = '0;
   logic          acc_rcpt = 1'b0;
   logic [3:0]    acc_delay = '0;
   logic [15:0]   acc_weight = '0;
   logic          rd_valid = 1'b0;
   logic [NW-1:0] rd_neuron = '0;
   logic          rd_rcpt = 1'b0;
   logic [3:0]    rd_shift = '0;
   logic          rd_data_valid;
   logic [31:0]   rd_data;

   int vecs = 0;
   int errs = 0;
   int unsigned model [N][2][16];
   int mptr = 0;

   always #10 clk = ~clk;

   syn_ring_accum #(.N_NEURONS(N)) u_syn_ring_accum (
      .clk(clk), .rst_n(rst_n), .step(step),
      .acc_valid(acc_valid), .acc_neuron(acc_neuron), .acc_rcpt(acc_rcpt),
      .acc_delay(acc_delay), .acc_weight(acc_weight),
      .rd_valid(rd_valid), .rd_neuron(rd_neuron), .rd_rcpt(rd_rcpt),
      .rd_shift(rd_shift), .rd_data_valid(rd_data_valid), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      vecs++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input bit av, input int an, input int ar, input int ad,
                      input int unsigned aw, input bit rv, input int rn, input int rr,
                      input int sh, input bit st, input string tag);
      longint unsigned exp_rd;
      int              slot;
      @(negedge clk);
      acc_valid = av; acc_neuron = NW'(an); acc_rcpt = ar[0];
      acc_delay = 4'(ad); acc_weight = 16'(aw);
      rd_valid = rv; rd_neuron = NW'(rn); rd_rcpt = rr[0]; rd_shift = 4'(sh);
      step = st;
      exp_rd = 0;
      if (rv) begin
         exp_rd = longint'(model[rn][rr][mptr]) << sh;
         model[rn][rr][mptr] = 0;
      end
      if (av) begin
         slot = (mptr + ad) % 16;
         model[an][ar][slot] = model[an][ar][slot] + aw;
         if (model[an][ar][slot] > 32'hFFFF) model[an][ar][slot] = 32'hFFFF;
      end
      if (st) mptr = (mptr + 1) % 16;
      @(posedge clk);
      #5;
      if (rv) begin
         check(rd_data_valid === 1'b1, {tag, " valid R6"}, longint'(rd_data_valid), 1);
         check(rd_data === exp_rd[31:0], tag, longint'(rd_data), longint'(exp_rd));
      end else begin
         check(rd_data_valid === 1'b0, {tag, " idle R6"}, longint'(rd_data_valid), 0);
      end
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
   endtask

   task automatic steps(input int k);
      for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "step R8");
   endtask

   initial begin
      #2000000;
      errs++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      for (int n = 0; n < N; n++)
         for (int r = 0; r < 2; r++)
            for (int s = 0; s < 16; s++) model[n][r][s] = 0;
      repeat (3) @(posedge clk);
      #5;
      // R1 reset state
      check(rd_data_valid === 1'b0, "R1 reset valid", longint'(rd_data_valid), 0);
      check(rd_data === 32'd0, "R1 reset data", longint'(rd_data), 0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: all rings empty
      for (int n = 0; n < N; n++)
         for (int r = 0; r < 2; r++) cyc(0, 0, 0, 0, 0, 1, n, r, 0, 0, "R1 empty");

      // R2 R3 R5: fill every ring at every delay; even delays get two weights
      for (int d = 0; d < 16; d++)
         for (int n = 0; n < N; n++)
            for (int r = 0; r < 2; r++) begin
               cyc(1, n, r, d, 1 + n*37 + r*300 + d*11, 0, 0, 0, 0, 0, "R2 load");
               if (d % 2 == 0) cyc(1, n, r, d, 5 + d, 0, 0, 0, 0, 0, "R3 load");
            end
      // Drain: read each ring per timestep; step together with the last read (R8)
      for (int s = 0; s < 16; s++)
         for (int b = 0; b < 2*N; b++)
            cyc(0, 0, 0, 0, 0, 1, b/2, b%2, s, (b == 2*N-1), "R2 R3 R5 R9 drain");

      // R4 saturation and exact ceiling
      cyc(1, 1, 1, 3, 16'hF000, 0, 0, 0, 0, 0, "R4 load");
      cyc(1, 1, 1, 3, 16'hF000, 0, 0, 0, 0, 0, "R4 load");
      cyc(1, 2, 0, 3, 16'h8000, 0, 0, 0, 0, 0, "R4 load");
      cyc(1, 2, 0, 3, 16'h7FFF, 0, 0, 0, 0, 0, "R4 load");
      steps(3);
      cyc(0, 0, 0, 0, 0, 1, 1, 1, 0, 0, "R4 saturated");
      cyc(0, 0, 0, 0, 0, 1, 2, 0, 0, 0, "R4 exact max");

      // R9 every shift on a full slot
      for (int sh = 0; sh < 16; sh++) begin
         cyc(1, 0, 0, 1, 16'hFFFF, 0, 0, 0, 0, 0, "R9 load");
         steps(1);
         cyc(0, 0, 0, 0, 0, 1, 0, 0, sh, 0, "R9 shift");
      end

      // R7 second read in one timestep returns zero
      cyc(1, 3, 1, 2, 77, 0, 0, 0, 0, 0, "R7 load");
      steps(2);
      cyc(0, 0, 0, 0, 0, 1, 3, 1, 0, 0, "R7 first read");
      cyc(0, 0, 0, 0, 0, 1, 3, 1, 0, 0, "R7 second read");

      // R10 collision: accumulate delay 0 and read the same slot together
      cyc(1, 2, 0, 5, 100, 0, 0, 0, 0, 0, "R10 preload");
      steps(5);
      cyc(1, 2, 0, 0, 55, 1, 2, 0, 0, 0, "R10 collide old value");
      cyc(0, 0, 0, 0, 0, 1, 2, 1, 0, 0, "R10 neighbour R5");
      steps(16);
      cyc(0, 0, 0, 0, 0, 1, 2, 0, 0, 0, "R10 kept weight");

      // R8 wrap: a weight 15 ahead appears after exactly 15 steps, not 14
      cyc(1, 0, 1, 15, 321, 0, 0, 0, 0, 0, "R8 load");
      steps(14);
      cyc(0, 0, 0, 0, 0, 1, 0, 1, 0, 0, "R8 early read");
      steps(1);
      cyc(0, 0, 0, 0, 0, 1, 0, 1, 2, 0, "R8 wrap read");
      idle();

      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule